// File: doc/BRIEF.md
# Plaintext Sequencer for Partial Header Protection

This block sits in the transmit path of a secured link, in front of an authenticated-encryption engine. Each memory-request descriptor it accepts carries a header size (3-DW or 4-DW), a request kind, a flit-mode flag, an optional-extension-header flag, a processing-hint bit, a 64-bit address, the two byte-enable nibbles and a payload length. It also carries a 4-bit protection mode. From these the block decides whether the byte-enable fields exist for that request. It selects a span of address bits from the mode. It then produces one byte stream for the cipher: the hidden header bytes come first, followed by the payload bytes it takes from a separate input stream.

While a request is in progress, the block also shows which header fields it has hidden: a flag for the byte enables and a 64-bit mask of hidden address bits. It raises an error flag when the mode value is reserved. All three streams (request, payload and plaintext) use valid/ready handshakes. The plaintext stream marks its final byte with a last flag.

Top module: `hdr_mask_sequencer`

## Requirements
- R1: With mode 0, no header bytes are emitted; the stream holds only the payload bytes. A request with mode 0 and zero payload length emits no byte.
- R2: Modes 1, 2, 3 and 4 hide address bits 2 up to bit 17, 25, 33 and 41 respectively. For a 4-DW header these are emitted as 2, 3, 4 and 5 bytes, taken from bit 2 upward, eight bits per byte, least significant bit first.
- R3: When flit mode is clear, the byte enables are present unless the kind is atomic (code 3) or translation (code 4), or the kind is read (code 0) or deferrable write (code 2) with the hint bit set. Write (code 1) and codes 5 to 7 always have them.
- R4: When flit mode is set, the byte enables are present exactly when the extension-header flag is set, whatever the kind and the hint bit.
- R5: Byte order is fixed: the byte-enable byte (when present and the mode is non-zero), then the address bytes, then the payload bytes in arrival order. No payload byte is taken while header bytes remain.
- R6: The byte-enable byte carries the last byte enable in bits [7:4] and the first byte enable in bits [3:0]. Address bits [1:0] and bits above 41 are never hidden.
- R7: With a 3-DW header, only address bits [31:0] exist. Bits above 31 are neither emitted nor marked hidden, even when set on the input. The byte count is the number of bytes needed for the existing bits (at most 4), and the top byte is padded with zeros.
- R8: Mode values 5 to 15 are reserved. They set the error flag for that request, and the request is handled as mode 0.
- R9: The last flag is high on the final byte of a request's stream and on no other byte. While a byte is offered and not accepted, the valid signal and the byte stay unchanged.
- R10: While a request is in progress (info valid high, starting the cycle after acceptance), the outputs hold its hidden-byte-enable flag, its hidden-address mask (bit i set when address bit i is hidden) and its error flag.
- R11: During and right after reset, the plaintext stream and the payload input are idle and a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor valid |
| req_ready | output | 1 | Descriptor accepted when both are high |
| req_mode | input | 4 | Protection mode (0 off, 1-4 spans, 5-15 reserved) |
| req_wide | input | 1 | 1 = 4-DW header (64-bit address), 0 = 3-DW |
| req_kind | input | 3 | Request kind code (see R3) |
| req_flit | input | 1 | Flit-mode flag |
| req_ext_a | input | 1 | Extension header with byte enables attached (flit mode) |
| req_hint | input | 1 | Processing-hint bit |
| req_addr | input | 64 | Request address |
| req_first_be | input | 4 | First byte enable |
| req_last_be | input | 4 | Last byte enable |
| req_len | input | 12 | Payload length in bytes |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| pt_valid | output | 1 | Plaintext byte valid |
| pt_ready | input | 1 | Plaintext byte accepted |
| pt_data | output | 8 | Plaintext byte |
| pt_last | output | 1 | Final byte of the request |
| info_valid | output | 1 | Request in progress; info outputs meaningful |
| info_be_hidden | output | 1 | Byte enables hidden for this request |
| info_addr_mask | output | 64 | Hidden address bits |
| info_mode_err | output | 1 | Reserved mode seen |

## Verification
Two events collide in the same cycle: a stall on the plaintext ready, and the handover from the last header byte to the first payload byte (or the final byte carrying the last flag). The bench drives ready at random with a low acceptance rate, and it starts payload bytes before their request's header bytes have drained. This produces stalls exactly at the header-to-payload boundary and on last bytes. Each stalled cycle is judged by requiring the same byte to be offered again in the next cycle. Each accepted byte is compared with a behavioural queue built from the requirements.

// File: rtl/hms_pkg.sv
package hms_pkg;

  // Highest legal protection mode; spans grow by one byte per step.
  localparam logic [3:0] MODE_TOP = 4'd4;

  typedef enum logic [2:0] {
    KIND_MRD  = 3'd0,
    KIND_MWR  = 3'd1,
    KIND_DMWR = 3'd2,
    KIND_ATOM = 3'd3,
    KIND_XLAT = 3'd4
  } req_kind_e;

  // Whether the byte-enable pair exists for this request.
  function automatic logic be_fields_exist(logic flit, logic ext_a,
                                           logic [2:0] kind, logic hint);
    if (flit) return ext_a;
    if (kind == KIND_ATOM || kind == KIND_XLAT) return 1'b0;
    if ((kind == KIND_MRD || kind == KIND_DMWR) && hint) return 1'b0;
    return 1'b1;
  endfunction

  // Top hidden address bit; 1 means nothing hidden.
  function automatic int span_top_bit(logic [3:0] mode, logic wide);
    int t;
    if (mode == 4'd0 || mode > MODE_TOP) return 1;
    t = 9 + 8 * int'(mode);
    if (!wide && t > 31) t = 31;
    return t;
  endfunction

  // Whole bytes needed for bits [top:2].
  function automatic int span_bytes(int top);
    if (top < 2) return 0;
    return (top - 2) / 8 + 1;
  endfunction

endpackage

// File: rtl/hms_classify.sv
module hms_classify
  import hms_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int MAX_AB    = 5,
  parameter int HDR_BYTES = MAX_AB + 1,
  parameter int CNT_W     = $clog2(HDR_BYTES + 1)
) (
  input  logic [3:0]                  mode,
  input  logic                        wide,
  input  logic                        flit,
  input  logic                        ext_a,
  input  logic [2:0]                  kind,
  input  logic                        hint,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [3:0]                  first_be,
  input  logic [3:0]                  last_be,
  output logic [HDR_BYTES-1:0][7:0]   hdr_bytes,
  output logic [CNT_W-1:0]            hdr_cnt,
  output logic [ADDR_W-1:0]           addr_mask,
  output logic                        be_hidden,
  output logic                        mode_bad
);

  logic [3:0]        eff_mode;
  int                top;
  logic [CNT_W-1:0]  n_addr;
  logic [ADDR_W-1:0] masked;
  logic [MAX_AB-1:0][7:0] addr_byte;

  always_comb begin
    mode_bad  = (mode > MODE_TOP);
    eff_mode  = mode_bad ? 4'd0 : mode;
    top       = span_top_bit(eff_mode, wide);
    for (int i = 0; i < ADDR_W; i++) addr_mask[i] = (i >= 2) && (i <= top);
    be_hidden = (eff_mode != 4'd0) && be_fields_exist(flit, ext_a, kind, hint);
    n_addr    = CNT_W'(span_bytes(top));
    masked    = addr & addr_mask;
  end

  // One plaintext byte per eight hidden address bits.
  for (genvar k = 0; k < MAX_AB; k++) begin : g_abyte
    assign addr_byte[k] = masked[2 + 8*k +: 8];
  end

  always_comb begin
    hdr_bytes = '0;
    if (be_hidden) hdr_bytes[0] = {last_be, first_be};
    for (int k = 0; k < MAX_AB; k++) begin
      if (k < int'(n_addr)) hdr_bytes[k + int'(be_hidden)] = addr_byte[k];
    end
    hdr_cnt = n_addr + CNT_W'(be_hidden);
  end

endmodule

// File: rtl/hms_hdr_store.sv
module hms_hdr_store
  import hms_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int HDR_BYTES = 6,
  parameter int CNT_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      adv,
  input  logic [HDR_BYTES-1:0][7:0] hdr_bytes_in,
  input  logic [CNT_W-1:0]          hdr_cnt_in,
  input  logic [ADDR_W-1:0]         mask_in,
  input  logic                      be_hidden_in,
  input  logic                      mode_bad_in,
  input  logic                      wide_in,
  output logic [7:0]                cur_byte,
  output logic                      hdr_left,
  output logic [ADDR_W-1:0]         mask_q,
  output logic                      be_hidden_q,
  output logic                      mode_bad_q
);

  localparam int SPAN_CEIL = 10 + 8 * int'(MODE_TOP);

  logic [HDR_BYTES-1:0][7:0] bytes_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          idx_q;
  logic                      wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q     <= '0;
      cnt_q       <= '0;
      idx_q       <= '0;
      mask_q      <= '0;
      be_hidden_q <= 1'b0;
      mode_bad_q  <= 1'b0;
      wide_q      <= 1'b0;
    end else if (load) begin
      bytes_q     <= hdr_bytes_in;
      cnt_q       <= hdr_cnt_in;
      idx_q       <= '0;
      mask_q      <= mask_in;
      be_hidden_q <= be_hidden_in;
      mode_bad_q  <= mode_bad_in;
      wide_q      <= wide_in;
    end else if (adv) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign hdr_left = (idx_q < cnt_q);
  assign cur_byte = bytes_q[idx_q];

  AST_CLEAR_BITS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[1:0] == 2'b00) && (mask_q[ADDR_W-1:SPAN_CEIL] == '0)); // R6
  AST_NARROW_NO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (mask_q[ADDR_W-1:32] == '0)); // R7
  AST_BAD_MODE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad_q |-> (mask_q == '0) && !be_hidden_q && (cnt_q == '0)); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= cnt_q); // R5
  AST_HDR_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_left && !adv && !load) |=> $stable(cur_byte)); // R9

endmodule

// File: rtl/hms_stream_ctrl.sv
module hms_stream_ctrl #(
  parameter int REM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REM_W-1:0] total_in,
  output logic             load,
  input  logic             hdr_left,
  input  logic [7:0]       hdr_byte,
  output logic             hdr_adv,
  input  logic             pl_valid,
  input  logic [7:0]       pl_data,
  output logic             pl_ready,
  output logic             pt_valid,
  input  logic             pt_ready,
  output logic [7:0]       pt_data,
  output logic             pt_last,
  output logic             busy
);

  logic [REM_W-1:0] remain_q;
  logic             pay_phase;
  logic             pt_fire;
  logic             done_now;

  assign req_ready = !busy;
  assign load      = req_valid && req_ready;
  assign pay_phase = busy && !hdr_left && (remain_q != '0);
  assign pt_valid  = (busy && hdr_left) || (pay_phase && pl_valid);
  assign pt_data   = hdr_left ? hdr_byte : pl_data;
  assign pt_last   = pt_valid && (remain_q == REM_W'(1));
  assign pl_ready  = pay_phase && pt_ready;
  assign pt_fire   = pt_valid && pt_ready;
  assign hdr_adv   = pt_fire && hdr_left;
  assign done_now  = busy && ((remain_q == '0) || (pt_fire && remain_q == REM_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      remain_q <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      remain_q <= total_in;
    end else begin
      if (done_now) busy <= 1'b0;
      if (pt_fire)  remain_q <= remain_q - 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_valid && !pt_ready && hdr_left) |=> (pt_valid && $stable(pt_data))); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_fire && pt_last) |=> !busy); // R9
  AST_PAY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> !hdr_left); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pt_valid && !pl_ready)); // R11

endmodule

// File: rtl/hdr_mask_sequencer.sv
module hdr_mask_sequencer
  import hms_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic              req_wide,
  input  logic [2:0]        req_kind,
  input  logic              req_flit,
  input  logic              req_ext_a,
  input  logic              req_hint,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [7:0]        pl_data,
  output logic              pt_valid,
  input  logic              pt_ready,
  output logic [7:0]        pt_data,
  output logic              pt_last,
  output logic              info_valid,
  output logic              info_be_hidden,
  output logic [ADDR_W-1:0] info_addr_mask,
  output logic              info_mode_err
);

  localparam int MAX_AB    = int'(MODE_TOP) + 1;
  localparam int HDR_BYTES = MAX_AB + 1;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);
  localparam int REM_W     = LEN_W + 1;

  logic [HDR_BYTES-1:0][7:0] c_bytes;
  logic [CNT_W-1:0]          c_cnt;
  logic [ADDR_W-1:0]         c_mask;
  logic                      c_be;
  logic                      c_bad;
  logic [REM_W-1:0]          total;
  logic                      load;
  logic                      hdr_left;
  logic                      hdr_adv;
  logic [7:0]                hdr_byte;

  hms_classify #(
    .ADDR_W(ADDR_W), .MAX_AB(MAX_AB), .HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)
  ) u_cls (
    .mode(req_mode), .wide(req_wide), .flit(req_flit), .ext_a(req_ext_a),
    .kind(req_kind), .hint(req_hint), .addr(req_addr),
    .first_be(req_first_be), .last_be(req_last_be),
    .hdr_bytes(c_bytes), .hdr_cnt(c_cnt), .addr_mask(c_mask),
    .be_hidden(c_be), .mode_bad(c_bad)
  );

  assign total = REM_W'(c_cnt) + REM_W'(req_len);

  hms_hdr_store #(
    .ADDR_W(ADDR_W), .HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(hdr_adv),
    .hdr_bytes_in(c_bytes), .hdr_cnt_in(c_cnt), .mask_in(c_mask),
    .be_hidden_in(c_be), .mode_bad_in(c_bad), .wide_in(req_wide),
    .cur_byte(hdr_byte), .hdr_left(hdr_left), .mask_q(info_addr_mask),
    .be_hidden_q(info_be_hidden), .mode_bad_q(info_mode_err)
  );

  hms_stream_ctrl #(.REM_W(REM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .total_in(total), .load(load), .hdr_left(hdr_left), .hdr_byte(hdr_byte),
    .hdr_adv(hdr_adv), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .pt_valid(pt_valid), .pt_ready(pt_ready),
    .pt_data(pt_data), .pt_last(pt_last), .busy(info_valid)
  );

endmodule

// File: tb/hdr_mask_sequencer_tb.sv
module hdr_mask_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic        req_wide = 1'b0;
  logic [2:0]  req_kind = '0;
  logic        req_flit = 1'b0;
  logic        req_ext_a = 1'b0;
  logic        req_hint = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_first_be = '0;
  logic [3:0]  req_last_be = '0;
  logic [11:0] req_len = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [7:0]  pl_data = '0;
  logic        pt_valid;
  logic        pt_ready = 1'b0;
  logic [7:0]  pt_data;
  logic        pt_last;
  logic        info_valid;
  logic        info_be_hidden;
  logic [63:0] info_addr_mask;
  logic        info_mode_err;

  always #2.5 clk = ~clk;

  hdr_mask_sequencer u_dut (.*);

  int checks = 0;
  int failures = 0;
  int ready_pct = 100;

  logic [7:0]  exp_q[$];
  bit          exp_last_q[$];
  string       exp_tag_q[$];
  logic [7:0]  pl_q[$];
  logic [63:0] inf_mask_q[$];
  bit          inf_be_q[$];
  bit          inf_err_q[$];
  string       inf_tag_q[$];

  bit pl_fire_n = 0;
  bit pend_info = 0;
  logic [63:0] p_mask; bit p_be; bit p_err; string p_tag;
  bit prev_stall = 0; logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: builds the expected plaintext bit by bit.
  task automatic send(input logic [3:0] mode, input bit wide, input logic [2:0] kind,
                      input bit flit, input bit ext, input bit hint,
                      input logic [63:0] addr, input logic [3:0] fbe,
                      input logic [3:0] lbe, input int len, input string tag);
    int m, hi, n;
    bit be;
    logic [63:0] mk;
    logic [7:0] v;
    m = (mode > 4) ? 0 : int'(mode);
    if (m == 0) be = 0;
    else if (flit) be = ext;
    else be = !(kind == 3 || kind == 4 || ((kind == 0 || kind == 2) && hint));
    hi = (m == 0) ? 1 : 9 + 8 * m;
    if (!wide && hi > 31) hi = 31;
    mk = '0;
    for (int i = 2; i <= hi; i++) mk[i] = 1'b1;
    n = 0;
    if (be) begin exp_q.push_back({lbe, fbe}); n++; end
    for (int b = 2; b <= hi; b += 8) begin
      v = '0;
      for (int j = 0; j < 8; j++) if (b + j <= hi) v[j] = addr[b + j];
      exp_q.push_back(v); n++;
    end
    for (int p = 0; p < len; p++) begin
      v = 8'($urandom);
      pl_q.push_back(v); exp_q.push_back(v); n++;
    end
    for (int i = 0; i < n; i++) begin
      exp_last_q.push_back(i == n - 1);
      exp_tag_q.push_back(tag);
    end
    inf_mask_q.push_back(mk); inf_be_q.push_back(be);
    inf_err_q.push_back(mode > 4); inf_tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1; req_mode = mode; req_wide = wide; req_kind = kind;
    req_flit = flit; req_ext_a = ext; req_hint = hint; req_addr = addr;
    req_first_be = fbe; req_last_be = lbe; req_len = 12'(len);
    do @(negedge clk); while (!(req_valid && req_ready));
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
    repeat (2) @(negedge clk);
  endtask

  // Monitor and scoreboard, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_info) begin
        chk(info_valid === 1'b1, p_tag, "R10 info_valid", 64'(info_valid), 64'd1);
        chk(info_addr_mask === p_mask, p_tag, "R10 addr mask", info_addr_mask, p_mask);
        chk(info_be_hidden === p_be, p_tag, "R10 be hidden", 64'(info_be_hidden), 64'(p_be));
        chk(info_mode_err === p_err, p_tag, "R8 mode err", 64'(info_mode_err), 64'(p_err));
        pend_info = 0;
      end
      if (req_valid && req_ready) begin
        p_mask = inf_mask_q.pop_front(); p_be = inf_be_q.pop_front();
        p_err = inf_err_q.pop_front(); p_tag = inf_tag_q.pop_front();
        pend_info = 1;
      end
      if (prev_stall) // R9 stall hold
        chk(pt_valid === 1'b1 && pt_data === prev_data, "R9", "stalled byte moved",
            64'(pt_data), 64'(prev_data));
      if (pt_valid && pt_ready) begin
        if (exp_q.size() == 0) chk(0, "R1", "unexpected byte", 64'(pt_data), 64'hx);
        else begin
          chk(pt_data === exp_q[0], exp_tag_q[0], "data", 64'(pt_data), 64'(exp_q[0]));
          chk(pt_last === exp_last_q[0], "R9", "last flag", 64'(pt_last), 64'(exp_last_q[0]));
          void'(exp_q.pop_front()); void'(exp_last_q.pop_front()); void'(exp_tag_q.pop_front());
        end
      end
      prev_stall = pt_valid && !pt_ready;
      prev_data  = pt_data;
    end
    pl_fire_n = pl_valid && pl_ready;
  end

  // Payload source and sink readiness.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (pl_fire_n) begin void'(pl_q.pop_front()); pl_valid = 0; end
      if (!pl_valid && pl_q.size() > 0 && ($urandom % 4 != 0)) begin
        pl_valid = 1; pl_data = pl_q[0];
      end
      pt_ready = (($urandom % 100) < ready_pct);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(pt_valid === 1'b0, "R11", "pt_valid in reset", 64'(pt_valid), 0);
    chk(pl_ready === 1'b0, "R11", "pl_ready in reset", 64'(pl_ready), 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && pt_valid === 1'b0, "R11", "idle after reset",
        64'({req_ready, pt_valid}), 64'b10);

    send(4'd0, 1, 3'd1, 0, 0, 0, 64'h0123_4567_89AB_CDEF, 4'hF, 4'hF, 4, "R1");
    send(4'd0, 1, 3'd1, 0, 0, 0, 64'hFFFF, 4'h1, 4'h2, 0, "R1");
    drain();
    for (int m = 1; m <= 4; m++) begin
      send(4'(m), 1, 3'd1, 0, 0, 0, 64'hA5C3_1E2D_3C4B_5A69, 4'h3, 4'hC, m + 1, "R2");
      send(4'(m), 1, 3'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h9, 4'h6, 0, "R6");
    end
    drain();
    send(4'd2, 1, 3'd3, 0, 0, 0, 64'h1234_5678, 4'hF, 4'h0, 2, "R3");
    send(4'd2, 1, 3'd4, 0, 0, 0, 64'h1234_5678, 4'hF, 4'h0, 0, "R3");
    send(4'd2, 1, 3'd0, 0, 0, 1, 64'h1234_5678, 4'hF, 4'h0, 0, "R3");
    send(4'd2, 1, 3'd2, 0, 0, 1, 64'h1234_5678, 4'hF, 4'h0, 3, "R3");
    send(4'd2, 1, 3'd0, 0, 0, 0, 64'h1234_5678, 4'h5, 4'hA, 0, "R3");
    send(4'd2, 1, 3'd1, 0, 0, 1, 64'h1234_5678, 4'h5, 4'hA, 2, "R3");
    send(4'd2, 1, 3'd6, 0, 0, 1, 64'h1234_5678, 4'h7, 4'hE, 1, "R3");
    send(4'd3, 1, 3'd1, 1, 0, 0, 64'hDEAD_BEEF_CAFE, 4'hF, 4'hF, 2, "R4");
    send(4'd3, 1, 3'd1, 1, 1, 0, 64'hDEAD_BEEF_CAFE, 4'h2, 4'h4, 2, "R4");
    send(4'd3, 1, 3'd3, 1, 1, 1, 64'hDEAD_BEEF_CAFE, 4'h8, 4'h1, 0, "R4");
    drain();
    send(4'd3, 0, 3'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hB, 4'hD, 2, "R7");
    send(4'd4, 0, 3'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hB, 4'hD, 1, "R7");
    send(4'd1, 0, 3'd4, 0, 0, 0, 64'hFFFF_0000_8765_4321, 4'hB, 4'hD, 0, "R7");
    send(4'd5, 1, 3'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 4'hF, 3, "R8");
    send(4'd15, 1, 3'd1, 0, 0, 0, 64'h1111, 4'hF, 4'hF, 0, "R8");
    drain();
    ready_pct = 30; // R9/R5 boundary stalls
    for (int i = 0; i < 60; i++)
      send(4'($urandom % 7), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), {$urandom, $urandom}, 4'($urandom), 4'($urandom),
           int'($urandom % 6), "R5");
    drain();
    ready_pct = 100;
    chk(exp_q.size() == 0 && pl_q.size() == 0, "R5", "queues drained",
        64'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule